// File: doc/BRIEF.md
# Software-Managed Translation Lookaside Buffer

This block holds the page translations of a processor whose memory-management unit is refilled by software. Each of its slots covers a pair of adjacent virtual pages, one even and one odd. The pair shares one virtual tag, one address-space identifier and one page-size mask. Each half has its own frame number, cache attribute, dirty bit and valid bit. Software never reaches the slots directly. It stages a translation in four staging registers (a high word, two low words and a mask word) plus an index word, and then issues one of four commands: write at the index, write at a random slot, search for the staged tag, or read the indexed slot back into the staging registers.

The register bank stays outside the block. On each command the block takes the current register values and returns the updated values one cycle later, together with a one-cycle completion pulse. The search compares every slot at the same time and finishes in one cycle. A miss is reported by setting the top bit of the returned index word.

Top module: `tlb_top`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle with `cmd_valid` high, and low at every other time. During reset, `done` and all five result words are zero.
- R2: The indexed write (`cmd_op` = 2'b00) stores into the slot `index_in` modulo the slot count, so only the low log2(slot count) bits are used. Both write commands return all five input words unchanged.
- R3: The random write (`cmd_op` = 2'b01) stores into the slot given by `rand_idx` and ignores `index_in`.
- R4: The indexed read (`cmd_op` = 2'b11) returns a high word that holds the stored tag in bits 31:13 and the stored identifier in bits 7:0. Bits 12:8 are zero.
- R5: The indexed read returns each low word with valid in bit 1, dirty in bit 2, the attribute in bits 5:3 and the frame number in bits 29:6. Bits 31:30 and bit 0 are zero.
- R6: A slot is global only when bit 0 of both written low words is 1. A global slot matches a search whatever its identifier.
- R7: A search (`cmd_op` = 2'b10) matches a slot when the slot tag equals `entryhi_in[31:13]` and either the slot is global or its identifier equals `entryhi_in[7:0]`. The valid bits take no part in matching.
- R8: On a search hit, the returned index word holds the lowest matching slot number, and every other bit is zero, including bit 31.
- R9: On a search miss, the returned index word is `index_in` with bit 31 forced to 1 and every other bit unchanged.
- R10: The indexed read returns the stored page-size mask in bits 24:13 of the mask word. All other bits are zero.
- R11: After reset, every slot has its valid, dirty, global, tag, identifier, frame and mask fields cleared.
- R12: A read returns `index_in` unchanged. A search returns the high, low and mask words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 00 indexed write, 01 random write, 10 search, 11 indexed read |
| index_in | input | 32 | Current index word |
| entryhi_in | input | 32 | Current high word (tag, identifier) |
| entrylo0_in | input | 32 | Current even-page low word |
| entrylo1_in | input | 32 | Current odd-page low word |
| pagemask_in | input | 32 | Current page-size mask word |
| rand_idx | input | 4 | Slot for the random write |
| index_out | output | 32 | Updated index word |
| entryhi_out | output | 32 | Updated high word |
| entrylo0_out | output | 32 | Updated even-page low word |
| entrylo1_out | output | 32 | Updated odd-page low word |
| pagemask_out | output | 32 | Updated mask word |
| done | output | 1 | Completion pulse, one cycle after a command |

## Verification
The bench builds the block with its default of 16 slots. At that size it can write, read back and search every slot, and drive `rand_idx` through all of its values. Index words of 16 and above bring the modulo wrap of the indexed commands within reach. Slots loaded with duplicate tags, and searches under an identifier that only global slots accept, exercise the lowest-slot priority and the rule that both halves must be global.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int WORD_W = 32;
    parameter int VPN_W  = 19;
    parameter int ASID_W = 8;
    parameter int PFN_W  = 24;
    parameter int ATTR_W = 3;
    parameter int MASK_W = 12;

    localparam int VPN_LSB  = WORD_W - VPN_W;
    localparam int MASK_LSB = 13;
    localparam int PFN_LSB  = 6;
    localparam int ATTR_LSB = 3;

    localparam logic [WORD_W-1:0] MISS_BIT = 32'h8000_0000;

    typedef enum logic [1:0] {
        OP_WR_IDX = 2'b00,
        OP_WR_RND = 2'b01,
        OP_PROBE  = 2'b10,
        OP_RD_IDX = 2'b11
    } tlb_op_e;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
    } half_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [MASK_W-1:0] mask;
        logic              glb;
        half_t             even;
        half_t             odd;
    } entry_t;

    function automatic half_t unpack_half(input logic [WORD_W-1:0] lo);
        half_t h;
        h.valid = lo[1];
        h.dirty = lo[2];
        h.attr  = lo[ATTR_LSB +: ATTR_W];
        h.pfn   = lo[PFN_LSB +: PFN_W];
        return h;
    endfunction

    function automatic logic [WORD_W-1:0] pack_half(input half_t h);
        logic [WORD_W-1:0] w;
        w = '0;
        w[1] = h.valid;
        w[2] = h.dirty;
        w[ATTR_LSB +: ATTR_W] = h.attr;
        w[PFN_LSB +: PFN_W]   = h.pfn;
        return w;
    endfunction

    function automatic entry_t build_entry(input logic [WORD_W-1:0] hi,
                                           input logic [WORD_W-1:0] lo0,
                                           input logic [WORD_W-1:0] lo1,
                                           input logic [WORD_W-1:0] pm);
        entry_t e;
        e.vpn  = hi[VPN_LSB +: VPN_W];
        e.asid = hi[ASID_W-1:0];
        e.mask = pm[MASK_LSB +: MASK_W];
        e.glb  = lo0[0] & lo1[0];
        e.even = unpack_half(lo0);
        e.odd  = unpack_half(lo1);
        return e;
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  entry_t                 wr_data,
    input  logic [IW-1:0]          rd_idx,
    output entry_t                 rd_data,
    output entry_t [NUM_ENTRIES-1:0] slots
);

    entry_t slot_q [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
        assign slots[g] = slot_q[g];
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  entry_t [NUM_ENTRIES-1:0] slots,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic                     hit,
    output logic [IW-1:0]            hit_idx
);

    logic [NUM_ENTRIES-1:0] match;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign match[g] = (slots[g].vpn == key_vpn) &&
                          (slots[g].glb || (slots[g].asid == key_asid));
    end

    always_comb begin
        hit_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/tlb_readback.sv
module tlb_readback
    import tlb_pkg::*;
(
    input  entry_t            slot,
    output logic [WORD_W-1:0] hi_word,
    output logic [WORD_W-1:0] lo0_word,
    output logic [WORD_W-1:0] lo1_word,
    output logic [WORD_W-1:0] pm_word
);

    always_comb begin
        hi_word = '0;
        hi_word[VPN_LSB +: VPN_W] = slot.vpn;
        hi_word[ASID_W-1:0]       = slot.asid;
        pm_word = '0;
        pm_word[MASK_LSB +: MASK_W] = slot.mask;
        lo0_word = pack_half(slot.even);
        lo1_word = pack_half(slot.odd);
    end

endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [31:0]   index_in,
    input  logic [31:0]   entryhi_in,
    input  logic [31:0]   entrylo0_in,
    input  logic [31:0]   entrylo1_in,
    input  logic [31:0]   pagemask_in,
    input  logic [IW-1:0] rand_idx,
    output logic [31:0]   index_out,
    output logic [31:0]   entryhi_out,
    output logic [31:0]   entrylo0_out,
    output logic [31:0]   entrylo1_out,
    output logic [31:0]   pagemask_out,
    output logic          done
);

    tlb_op_e op;
    assign op = tlb_op_e'(cmd_op);

    logic                      wr_en;
    logic [IW-1:0]             wr_idx;
    logic [IW-1:0]             rd_idx;
    entry_t                    wr_data;
    entry_t                    rd_data;
    entry_t [NUM_ENTRIES-1:0]  slots;
    logic                      hit;
    logic [IW-1:0]             hit_idx;
    logic [31:0]               rb_hi, rb_lo0, rb_lo1, rb_pm;
    logic [31:0]               probe_index;

    assign wr_en   = cmd_valid && (op == OP_WR_IDX || op == OP_WR_RND);
    assign wr_idx  = (op == OP_WR_RND) ? rand_idx : index_in[IW-1:0];
    assign rd_idx  = index_in[IW-1:0];
    assign wr_data = build_entry(entryhi_in, entrylo0_in, entrylo1_in, pagemask_in);

    tlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .slots   (slots)
    );

    tlb_probe #(.NUM_ENTRIES(NUM_ENTRIES)) u_probe (
        .slots    (slots),
        .key_vpn  (entryhi_in[VPN_LSB +: VPN_W]),
        .key_asid (entryhi_in[ASID_W-1:0]),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    tlb_readback u_rb (
        .slot     (rd_data),
        .hi_word  (rb_hi),
        .lo0_word (rb_lo0),
        .lo1_word (rb_lo1),
        .pm_word  (rb_pm)
    );

    always_comb begin
        probe_index = index_in | MISS_BIT;
        if (hit) probe_index = 32'(hit_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done         <= 1'b0;
            index_out    <= '0;
            entryhi_out  <= '0;
            entrylo0_out <= '0;
            entrylo1_out <= '0;
            pagemask_out <= '0;
        end else begin
            done <= cmd_valid;
            if (cmd_valid) begin
                index_out    <= index_in;
                entryhi_out  <= entryhi_in;
                entrylo0_out <= entrylo0_in;
                entrylo1_out <= entrylo1_in;
                pagemask_out <= pagemask_in;
                case (op)
                    OP_PROBE: index_out <= probe_index;
                    OP_RD_IDX: begin
                        entryhi_out  <= rb_hi;
                        entrylo0_out <= rb_lo0;
                        entrylo1_out <= rb_lo1;
                        pagemask_out <= rb_pm;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tlb_top_chk.sv
module tlb_top_chk #(
    parameter int NUM_ENTRIES = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic [31:0] index_in,
    input logic [31:0] entryhi_in,
    input logic [31:0] entrylo0_in,
    input logic [31:0] entrylo1_in,
    input logic [31:0] pagemask_in,
    input logic [31:0] index_out,
    input logic [31:0] entryhi_out,
    input logic [31:0] entrylo0_out,
    input logic [31:0] entrylo1_out,
    input logic [31:0] pagemask_out,
    input logic        done
);

    // R1
    done_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> done);

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !done);

    // R2
    write_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_op[1]) |=>
            (index_out == $past(index_in) && entryhi_out == $past(entryhi_in) &&
             entrylo0_out == $past(entrylo0_in) && entrylo1_out == $past(entrylo1_in) &&
             pagemask_out == $past(pagemask_in)));

    // R8 R9
    probe_index_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b10) |=>
            (index_out[31] ? (index_out == ($past(index_in) | 32'h8000_0000))
                           : (index_out < 32'(NUM_ENTRIES))));

    // R12
    probe_keeps_regs_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b10) |=>
            (entryhi_out == $past(entryhi_in) && entrylo0_out == $past(entrylo0_in) &&
             entrylo1_out == $past(entrylo1_in) && pagemask_out == $past(pagemask_in)));

    // R12
    read_keeps_index_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b11) |=> index_out == $past(index_in));

    // R4
    read_hi_format_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b11) |=> entryhi_out[12:8] == 5'd0);

    // R5
    read_lo_format_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b11) |=>
            (entrylo0_out[31:30] == 2'd0 && !entrylo0_out[0] &&
             entrylo1_out[31:30] == 2'd0 && !entrylo1_out[0]));

    // R10
    read_pm_format_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b11) |=>
            (pagemask_out[31:25] == 7'd0 && pagemask_out[12:0] == 13'd0));

    // R1
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(index_out) && $stable(entryhi_out) &&
                        $stable(entrylo0_out) && $stable(entrylo1_out) &&
                        $stable(pagemask_out)));

endmodule

bind tlb_top tlb_top_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .index_in     (index_in),
    .entryhi_in   (entryhi_in),
    .entrylo0_in  (entrylo0_in),
    .entrylo1_in  (entrylo1_in),
    .pagemask_in  (pagemask_in),
    .index_out    (index_out),
    .entryhi_out  (entryhi_out),
    .entrylo0_out (entrylo0_out),
    .entrylo1_out (entrylo1_out),
    .pagemask_out (pagemask_out),
    .done         (done)
);

// File: tb/sim_tlb_top.sv
module sim_tlb_top;

    localparam int N = 16;
    localparam logic [1:0] WRI = 2'b00, WRR = 2'b01, PRB = 2'b10, RDI = 2'b11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] index_in = '0, entryhi_in = '0, entrylo0_in = '0;
    logic [31:0] entrylo1_in = '0, pagemask_in = '0;
    logic [3:0]  rand_idx = '0;
    logic [31:0] index_out, entryhi_out, entrylo0_out, entrylo1_out, pagemask_out;
    logic        done;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [31:0] m_hi [N];
    logic [31:0] m_lo0 [N];
    logic [31:0] m_lo1 [N];
    logic [31:0] m_pm [N];
    logic        m_g [N];

    always #2 clk = ~clk;

    tlb_top #(.NUM_ENTRIES(N)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .index_in(index_in), .entryhi_in(entryhi_in), .entrylo0_in(entrylo0_in),
        .entrylo1_in(entrylo1_in), .pagemask_in(pagemask_in), .rand_idx(rand_idx),
        .index_out(index_out), .entryhi_out(entryhi_out), .entrylo0_out(entrylo0_out),
        .entrylo1_out(entrylo1_out), .pagemask_out(pagemask_out), .done(done)
    );

    function automatic logic [31:0] pat(input int s);
        return (32'(s) * 32'h9E37_79B1) ^ (32'(s) << 7) ^ 32'h0BAD_F00D;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, got, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [31:0] idx,
                         input logic [31:0] hi, input logic [31:0] lo0,
                         input logic [31:0] lo1, input logic [31:0] pm,
                         input logic [3:0] rnd);
        @(negedge clk);
        cmd_op = op; index_in = idx; entryhi_in = hi; entrylo0_in = lo0;
        entrylo1_in = lo1; pagemask_in = pm; rand_idx = rnd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic mdl_write(input int e, input logic [31:0] hi, input logic [31:0] lo0,
                             input logic [31:0] lo1, input logic [31:0] pm);
        m_hi[e]  = hi & 32'hFFFF_E0FF;
        m_lo0[e] = lo0 & 32'h3FFF_FFFE;
        m_lo1[e] = lo1 & 32'h3FFF_FFFE;
        m_pm[e]  = pm & 32'h01FF_E000;
        m_g[e]   = lo0[0] & lo1[0];
    endtask

    function automatic logic [31:0] mdl_probe(input logic [31:0] hi, input logic [31:0] idx);
        for (int i = 0; i < N; i++) begin
            if (m_hi[i][31:13] == hi[31:13] && (m_g[i] || m_hi[i][7:0] == hi[7:0]))
                return 32'(i);
        end
        return idx | 32'h8000_0000;
    endfunction

    task automatic do_write(input string req, input logic [1:0] op, input logic [31:0] idx,
                            input logic [3:0] rnd, input logic [31:0] hi,
                            input logic [31:0] lo0, input logic [31:0] lo1,
                            input logic [31:0] pm);
        issue(op, idx, hi, lo0, lo1, pm, rnd);
        mdl_write((op == WRR) ? int'(rnd) : int'(idx[3:0]), hi, lo0, lo1, pm);
        chk("R1", "done after write", {31'd0, done}, 32'd1);
        chk(req, "write index passthru", index_out, idx);
        chk(req, "write hi passthru", entryhi_out, hi);
        chk(req, "write lo0 passthru", entrylo0_out, lo0);
        chk(req, "write lo1 passthru", entrylo1_out, lo1);
        chk(req, "write pm passthru", pagemask_out, pm);
    endtask

    task automatic do_read(input string req, input logic [31:0] idx);
        int e;
        e = int'(idx[3:0]);
        issue(RDI, idx, 32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd0);
        chk("R12", "read index kept", index_out, idx);
        chk({req, " R4"}, "read hi", entryhi_out, m_hi[e]);
        chk({req, " R5"}, "read lo0", entrylo0_out, m_lo0[e]);
        chk({req, " R5"}, "read lo1", entrylo1_out, m_lo1[e]);
        chk({req, " R10"}, "read pm", pagemask_out, m_pm[e]);
    endtask

    task automatic do_probe(input string req, input logic [31:0] hi, input logic [31:0] idx);
        issue(PRB, idx, hi, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0F0F_0F0F, 4'd0);
        chk(req, "probe index", index_out, mdl_probe(hi, idx));
        chk("R12", "probe hi kept", entryhi_out, hi);
        chk("R12", "probe lo0 kept", entrylo0_out, 32'hA5A5_A5A5);
    endtask

    task automatic load_entry(input logic [1:0] op, input int e, input int s,
                              input logic [31:0] idx, input logic [3:0] rnd);
        logic [31:0] lo0, lo1;
        lo0 = (pat(s + 1) & ~32'd1) | 32'((e % 4) == 0 || (e % 4) == 1);
        lo1 = (pat(s + 2) & ~32'd1) | 32'((e % 4) == 0 || (e % 4) == 2);
        do_write((op == WRR) ? "R3" : "R2", op, idx, rnd, pat(s), lo0, lo1, pat(s + 3));
    endtask

    initial begin
        for (int i = 0; i < N; i++) mdl_write(i, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R11 R1: reset state at the ports
        chk("R1", "reset done", {31'd0, done}, 32'd0);
        chk("R1", "reset index", index_out, 32'd0);
        chk("R1", "reset hi", entryhi_out, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "idle done", {31'd0, done}, 32'd0);
        // R11: every slot reads back cleared
        for (int i = 0; i < N; i++) do_read("R11", 32'(i));
        // R7: valid bit ignored, cleared slot 0 matches tag 0 / id 0
        do_probe("R7", 32'h0000_0000, 32'h0000_0007);
        // R11: global cleared after reset, so another id misses (R9)
        do_probe("R11 R9", 32'h0000_0005, 32'h0000_0007);
        // R2: indexed writes, index words 16..31 wrap onto slots 0..15
        for (int i = 0; i < N; i++) load_entry(WRI, i, 10 * i, 32'(i + 16), 4'd0);
        for (int i = 0; i < N; i++) do_read("R2", 32'(i + 48));
        // R8: own-tag search hits each slot
        for (int i = 0; i < N; i++) do_probe("R8", m_hi[i], 32'h0000_0003);
        // R6: foreign id hits only slots with both global bits set
        for (int i = 0; i < N; i++)
            do_probe("R6", m_hi[i] ^ 32'h0000_005A, 32'h0000_0100 + 32'(i));
        // R9: tag absent from every slot
        do_probe("R9", 32'hFFFF_E0AB, 32'h7654_3219);
        // R3: random writes over every rand value, index word points elsewhere
        for (int r = 0; r < N; r++)
            load_entry(WRR, r, 500 + 7 * r, 32'((r + 5) % N), 4'(r));
        for (int i = 0; i < N; i++) do_read("R3", 32'(i));
        // R8: duplicate tags, lowest slot wins
        do_write("R2", WRI, 32'd11, 4'd0, 32'hCAFE_A033, 32'h0000_0002, 32'h0, 32'h0);
        do_write("R2", WRI, 32'd4, 4'd0, 32'hCAFE_A033, 32'h0000_0006, 32'h0, 32'h0);
        do_probe("R8", 32'hCAFE_A033, 32'h0);
        // R6: only one half global gives a non-global slot
        do_write("R6", WRI, 32'd2, 4'd0, 32'h1111_2044, 32'h0000_0001, 32'h0, 32'h0);
        do_probe("R6", 32'h1111_2045, 32'h0000_0009);
        do_write("R6", WRI, 32'd2, 4'd0, 32'h1111_2044, 32'h0000_0001, 32'h1, 32'h0);
        do_probe("R6", 32'h1111_2045, 32'h0000_0009);
        // R1: no stray pulse when idle
        @(negedge clk);
        chk("R1", "done low idle", {31'd0, done}, 32'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule